// File: doc/BRIEF.md
# UART Interrupt Identification and Prioritization

This block gathers the interrupt conditions of a UART (receive line errors, receive data available or receive character timeout, transmit holding register empty, and modem input change) and reports the most urgent enabled one to the CPU through an 8-bit identification value. It also drives one interrupt request line, which is high whenever an enabled source is pending. The surrounding UART supplies event pulses and level conditions, the per-source enable bits, the FIFO mode bit, and the strobes for the CPU's register accesses.

While the CPU holds the identification read strobe, the value on the read port does not change. Sources keep being recorded in that time and become visible once the strobe drops. The transmit-empty source is acknowledged by the identification read that reports it, or by a write to the transmit holding register. It is raised only on a rising edge of the empty condition.

Top module: `uart_irq_ident`

## Requirements
- R1: When several enabled sources are pending, the reported one is chosen in this order, highest first: line error, receive class (data or timeout), transmit empty, modem change.
- R2: Bit 0 of `iir_out` is 1 and `irq` is 0 when no enabled source is pending. Otherwise bit 0 is 0 and `irq` is 1. `irq` follows the live pending state even while `iir_out` is frozen.
- R3: Bits 3:0 read 0001 for none, 0110 for line error, 0100 for receive data, 1100 for receive timeout, 0010 for transmit empty, and 0000 for modem change.
- R4: Bit 3 is set only for a receive timeout, and a timeout can be pending only in FIFO mode. A `rx_tmo_evt` pulse while `fifo_en` is 0 has no effect. When both timeout and data are pending, the timeout code 1100 is reported.
- R5: Bits 5:4 always read 0. Bits 7:6 both equal `fifo_en`.
- R6: While `iir_rd` stays high, `iir_out` keeps the value it showed in the first cycle of the read. Events during the read are recorded and appear once `iir_rd` falls.
- R7: A line error pending is cleared by `lsr_rd`. A modem change pending is cleared by `msr_rd`.
- R8: A transmit-empty pending is cleared by `thr_wr`, or by an `iir_rd` read whose first cycle reports code 0010. A read that reports another code leaves it pending.
- R9: Receive data available follows the level of `rx_avail`. A pending receive timeout is cleared by `rbr_rd`.
- R10: A transmit-empty pending is set only on a rising edge of `thr_empty`. A level that is already high at reset, or stays high after a clear, raises nothing.
- R11: `src_en` bit 0 enables line error, bit 1 the receive class, bit 2 transmit empty, and bit 3 modem change. A disabled source is still recorded and is reported once it is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | FIFO mode enable |
| src_en | input | 4 | Per-source interrupt enables (see R11) |
| ls_err_evt | input | 1 | One-cycle pulse on a receive line error |
| rx_avail | input | 1 | Level: receive data at or above the trigger point |
| rx_tmo_evt | input | 1 | One-cycle pulse on a receive character timeout |
| thr_empty | input | 1 | Level: transmit holding register empty |
| modem_chg_evt | input | 1 | One-cycle pulse on a modem input change |
| iir_rd | input | 1 | CPU read of the identification register, held for the access |
| lsr_rd | input | 1 | CPU read of the line status register |
| msr_rd | input | 1 | CPU read of the modem status register |
| rbr_rd | input | 1 | CPU read of the receive buffer |
| thr_wr | input | 1 | CPU write of the transmit holding register |
| iir_out | output | 8 | Identification value seen by the CPU |
| irq | output | 1 | Interrupt request |

## Verification
A wrong pending bit shows on `irq` and in bits 3:0 of `iir_out` in the cycle after the pulse that sets or clears it. A wrong receive data level shows in the same cycle. A stale or missing snapshot shows as `iir_out` changing in the second cycle of a held read, or as a value that is still frozen once `iir_rd` falls. A transmit-empty acknowledge applied on the wrong read shows as code 0010 that stays, or that vanishes, once a read has ended.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int IIR_W = 8;
    localparam int SRC_N = 4;
    localparam int CODE_W = 4;

    // Bit positions of the source enable vector
    localparam int EN_LS   = 0;
    localparam int EN_RX   = 1;
    localparam int EN_THRE = 2;
    localparam int EN_MSR  = 3;

    typedef enum logic [CODE_W-1:0] {
        ID_NONE = 4'b0001,
        ID_LS   = 4'b0110,
        ID_RDA  = 4'b0100,
        ID_TMO  = 4'b1100,
        ID_THRE = 4'b0010,
        ID_MSR  = 4'b0000
    } iid_e;

    typedef struct packed {
        logic ls;
        logic rda;
        logic tmo;
        logic thre;
        logic msr;
    } pend_t;

endpackage

// File: rtl/uart_irq_src.sv
module uart_irq_src
    import uart_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  fifo_en,
    input  logic  ls_err_evt,
    input  logic  rx_avail,
    input  logic  rx_tmo_evt,
    input  logic  thr_empty,
    input  logic  modem_chg_evt,
    input  logic  lsr_rd,
    input  logic  msr_rd,
    input  logic  rbr_rd,
    input  logic  thr_wr,
    input  logic  thre_ack,
    output pend_t pend
);

    typedef struct packed {
        logic ls;
        logic tmo;
        logic thre;
        logic msr;
        logic thr_prev;
    } src_state_t;

    src_state_t s_d, s_q;
    logic       thre_set;

    always_comb begin
        s_d      = s_q;
        thre_set = thr_empty && !s_q.thr_prev;

        s_d.thr_prev = thr_empty;

        // set takes precedence over clear in the same cycle
        if (ls_err_evt)  s_d.ls = 1'b1;
        else if (lsr_rd) s_d.ls = 1'b0;

        if (!fifo_en)        s_d.tmo = 1'b0;
        else if (rx_tmo_evt) s_d.tmo = 1'b1;
        else if (rbr_rd)     s_d.tmo = 1'b0;

        if (thre_set)                s_d.thre = 1'b1;
        else if (thr_wr || thre_ack) s_d.thre = 1'b0;

        if (modem_chg_evt) s_d.msr = 1'b1;
        else if (msr_rd)   s_d.msr = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.ls       <= 1'b0;
            s_q.tmo      <= 1'b0;
            s_q.thre     <= 1'b0;
            s_q.msr      <= 1'b0;
            s_q.thr_prev <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        pend.ls   = s_q.ls;
        pend.rda  = rx_avail;
        pend.tmo  = s_q.tmo;
        pend.thre = s_q.thre;
        pend.msr  = s_q.msr;
    end

    a_r7_ls_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd && !ls_err_evt) |=> !s_q.ls);

    a_r8_thre_write_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_wr && !(thr_empty && !s_q.thr_prev)) |=> !s_q.thre);

    a_r10_thre_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.thre) |-> ($past(thr_empty) && !$past(s_q.thr_prev)));

    a_r4_tmo_needs_fifo: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en |=> !s_q.tmo);

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  pend_t            pend,
    input  logic [SRC_N-1:0] src_en,
    input  logic             fifo_en,
    output logic [IIR_W-1:0] iir_live,
    output logic             any_pend
);

    iid_e code;

    always_comb begin
        if (pend.ls && src_en[EN_LS])                      code = ID_LS;
        else if (pend.tmo && fifo_en && src_en[EN_RX])     code = ID_TMO;
        else if (pend.rda && src_en[EN_RX])                code = ID_RDA;
        else if (pend.thre && src_en[EN_THRE])             code = ID_THRE;
        else if (pend.msr && src_en[EN_MSR])               code = ID_MSR;
        else                                               code = ID_NONE;

        any_pend = (code != ID_NONE);
        iir_live = {fifo_en, fifo_en, 2'b00, code};
    end

endmodule

// File: rtl/uart_irq_hold.sv
module uart_irq_hold
    import uart_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iir_rd,
    input  logic [IIR_W-1:0] iir_live,
    output logic [IIR_W-1:0] iir_out,
    output logic             rd_start
);

    typedef struct packed {
        logic             active;
        logic [IIR_W-1:0] snap;
    } hold_state_t;

    hold_state_t h_d, h_q;

    always_comb begin
        h_d        = h_q;
        rd_start   = iir_rd && !h_q.active;
        h_d.active = iir_rd;
        if (rd_start) h_d.snap = iir_live;
        iir_out = (iir_rd && h_q.active) ? h_q.snap : iir_live;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_q.active <= 1'b0;
            h_q.snap   <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    a_r6_frozen_during_read: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_rd && h_q.active) |=> (!iir_rd || $stable(iir_out)));

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic [SRC_N-1:0] src_en,
    input  logic             ls_err_evt,
    input  logic             rx_avail,
    input  logic             rx_tmo_evt,
    input  logic             thr_empty,
    input  logic             modem_chg_evt,
    input  logic             iir_rd,
    input  logic             lsr_rd,
    input  logic             msr_rd,
    input  logic             rbr_rd,
    input  logic             thr_wr,
    output logic [IIR_W-1:0] iir_out,
    output logic             irq
);

    pend_t            pend;
    logic [IIR_W-1:0] iir_live;
    logic             any_pend;
    logic             rd_start;
    logic             thre_ack;

    // acknowledge transmit empty only when the read's first cycle reports it
    assign thre_ack = rd_start && (iir_live[CODE_W-1:0] == ID_THRE);
    assign irq      = any_pend;

    uart_irq_src u_src (
        .clk           (clk),
        .rst_n         (rst_n),
        .fifo_en       (fifo_en),
        .ls_err_evt    (ls_err_evt),
        .rx_avail      (rx_avail),
        .rx_tmo_evt    (rx_tmo_evt),
        .thr_empty     (thr_empty),
        .modem_chg_evt (modem_chg_evt),
        .lsr_rd        (lsr_rd),
        .msr_rd        (msr_rd),
        .rbr_rd        (rbr_rd),
        .thr_wr        (thr_wr),
        .thre_ack      (thre_ack),
        .pend          (pend)
    );

    uart_irq_prio u_prio (
        .pend     (pend),
        .src_en   (src_en),
        .fifo_en  (fifo_en),
        .iir_live (iir_live),
        .any_pend (any_pend)
    );

    uart_irq_hold u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .iir_rd   (iir_rd),
        .iir_live (iir_live),
        .iir_out  (iir_out),
        .rd_start (rd_start)
    );

endmodule

// File: tb/sim_uart_irq_ident.sv
module sim_uart_irq_ident;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b0;
    logic [3:0] src_en = 4'hF;
    logic       ls_err_evt = 1'b0, rx_avail = 1'b0, rx_tmo_evt = 1'b0;
    logic       thr_empty = 1'b1, modem_chg_evt = 1'b0;
    logic       iir_rd = 1'b0, lsr_rd = 1'b0, msr_rd = 1'b0, rbr_rd = 1'b0, thr_wr = 1'b0;
    logic [7:0] iir_out;
    logic       irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    uart_irq_ident u0 (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .src_en(src_en),
        .ls_err_evt(ls_err_evt), .rx_avail(rx_avail), .rx_tmo_evt(rx_tmo_evt),
        .thr_empty(thr_empty), .modem_chg_evt(modem_chg_evt), .iir_rd(iir_rd),
        .lsr_rd(lsr_rd), .msr_rd(msr_rd), .rbr_rd(rbr_rd), .thr_wr(thr_wr),
        .iir_out(iir_out), .irq(irq)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [7:0] exp_iir, logic exp_irq);
        #1;
        n_tests++;
        if (iir_out !== exp_iir || irq !== exp_irq) begin
            n_fail++;
            $display("FAIL %s: iir=%02h irq=%0b expected iir=%02h irq=%0b",
                     req, iir_out, irq, exp_iir, exp_irq);
        end
    endtask

    task automatic t_reset();
        // R10: empty already high through reset raises nothing
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R2 reset idle", 8'h01, 1'b0);
        tick();
        chk("R10 no set from level at reset", 8'h01, 1'b0);
        thr_empty = 1'b0;
        tick();
    endtask

    task automatic t_priority();
        fifo_en = 1'b1;
        tick();
        chk("R5 fifo bits", 8'hC1, 1'b0);
        ls_err_evt = 1'b1; rx_avail = 1'b1; thr_empty = 1'b1; modem_chg_evt = 1'b1;
        tick();
        ls_err_evt = 1'b0; modem_chg_evt = 1'b0;
        chk("R1 line error first", 8'hC6, 1'b1);
        lsr_rd = 1'b1; tick(); lsr_rd = 1'b0;
        chk("R7 lsr clears, R1 rx next", 8'hC4, 1'b1);
        rx_avail = 1'b0;
        chk("R9 rx level drop, R1 thre next", 8'hC2, 1'b1);
        iir_rd = 1'b1;
        tick();
        chk("R6 R8 read reports thre", 8'hC2, 1'b1);
        iir_rd = 1'b0;
        chk("R8 thre acked, R1 modem last", 8'hC0, 1'b1);
        msr_rd = 1'b1; tick(); msr_rd = 1'b0;
        chk("R7 msr clears", 8'hC1, 1'b0);
    endtask

    task automatic t_timeout();
        rx_tmo_evt = 1'b1; tick(); rx_tmo_evt = 1'b0;
        chk("R3 R4 timeout code", 8'hCC, 1'b1);
        rx_avail = 1'b1;
        chk("R4 timeout over data", 8'hCC, 1'b1);
        rbr_rd = 1'b1; tick(); rbr_rd = 1'b0;
        chk("R9 rbr clears timeout", 8'hC4, 1'b1);
        rx_avail = 1'b0;
        fifo_en = 1'b0;
        tick();
        chk("R5 non-fifo idle", 8'h01, 1'b0);
        rx_tmo_evt = 1'b1; tick(); rx_tmo_evt = 1'b0;
        tick();
        chk("R4 timeout ignored non-fifo", 8'h01, 1'b0);
        rx_avail = 1'b1;
        chk("R3 data code non-fifo", 8'h04, 1'b1);
        rx_avail = 1'b0;
        fifo_en = 1'b1;
        tick();
    endtask

    task automatic t_freeze();
        iir_rd = 1'b1;
        tick();
        ls_err_evt = 1'b1; tick(); ls_err_evt = 1'b0;
        chk("R6 frozen while event lands, R2 irq live", 8'hC1, 1'b1);
        tick();
        chk("R6 still frozen", 8'hC1, 1'b1);
        iir_rd = 1'b0;
        chk("R6 event visible after read", 8'hC6, 1'b1);
        lsr_rd = 1'b1; tick(); lsr_rd = 1'b0;
        chk("R7 lsr clears after freeze", 8'hC1, 1'b0);
    endtask

    task automatic t_thre();
        // thr_empty still high after the ack in t_priority
        chk("R10 level held after ack", 8'hC1, 1'b0);
        thr_empty = 1'b0; tick(); thr_empty = 1'b1; tick();
        chk("R10 new rising edge", 8'hC2, 1'b1);
        thr_wr = 1'b1; tick(); thr_wr = 1'b0;
        chk("R8 thr write clears", 8'hC1, 1'b0);
        thr_empty = 1'b0; tick(); thr_empty = 1'b1; tick();
        ls_err_evt = 1'b1; tick(); ls_err_evt = 1'b0;
        chk("R1 line error over thre", 8'hC6, 1'b1);
        iir_rd = 1'b1; tick(); iir_rd = 1'b0;
        lsr_rd = 1'b1; tick(); lsr_rd = 1'b0;
        chk("R8 read of other code keeps thre", 8'hC2, 1'b1);
        iir_rd = 1'b1; tick(); iir_rd = 1'b0;
        chk("R8 read reporting thre clears", 8'hC1, 1'b0);
        tick();
        chk("R10 no re-set while high", 8'hC1, 1'b0);
    endtask

    task automatic t_enable();
        src_en = 4'b0111;
        modem_chg_evt = 1'b1; tick(); modem_chg_evt = 1'b0;
        chk("R11 disabled modem hidden", 8'hC1, 1'b0);
        src_en = 4'b1111;
        chk("R11 retained modem shown", 8'hC0, 1'b1);
        src_en = 4'b1101;
        rx_avail = 1'b1;
        chk("R11 rx class disabled", 8'hC0, 1'b1);
        rx_avail = 1'b0;
        src_en = 4'b1111;
        msr_rd = 1'b1; tick(); msr_rd = 1'b0;
        chk("R7 msr clear end", 8'hC1, 1'b0);
    endtask

    initial begin
        t_reset();
        t_priority();
        t_timeout();
        t_freeze();
        t_thre();
        t_enable();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule